// File: doc/BRIEF.md
# Per-Channel Echo Canceller Path Controller

This block controls the receive and send sample paths around an echo canceller that is shared by many voice channels in time order. Samples arrive one channel at a time. A frame strobe starts each frame, and the controller numbers the samples that follow it 0, 1, 2 and so on. For every channel it keeps a staged copy and a live copy of four control bits: send mute, receive mute, bypass and adaptation off. A staged write becomes live only at the next frame strobe.

On the receive path each sample is delayed by a fixed number of that channel's own frames. The send path does the same with the echo-reduced value. In bypass, the raw send sample is delayed instead, by the shorter bypass delay. Muting replaces an output with a quiet code. Toward the filter the block emits, for each sample, a coefficient-clear request, an adaptation-enable level, and a flag that says the clear has been in force for a whole frame. The filter is not part of this block. A stub subtracts the supplied echo estimate from the send sample.

Top module: `echo_path_ctrl`

## Requirements
- R1: When the live receive-mute bit (ctrlBits[1]) of a channel is set, that channel's routData carries QUIET_CODE.
- R2: When the live send-mute bit (ctrlBits[0]) of a channel is set, that channel's soutData carries QUIET_CODE.
- R3: Mute takes priority over bypass: a muted output carries QUIET_CODE even while bypass (ctrlBits[2]) is live.
- R4: routData for a channel is the rinData of that same channel from exactly RX_DLY (default 2) of its frames earlier, or 0 before that many frames exist.
- R5: Outside bypass, soutData is (sinData − echoEst) modulo 256 of that channel from exactly TX_DLY (default 3) frames earlier, or 0 before that.
- R6: In bypass, soutData is the unmodified sinData from exactly BYP_DLY (default 2) frames earlier, and routData keeps its R4 behaviour.
- R7: A control write is staged and takes effect only from the first sample after the next frameSync. Samples later in the same frame still use the old bits.
- R8: For each output sample, coefClear is high exactly when the channel is in bypass. adaptEn is high exactly when neither bypass nor adaptation-off (ctrlBits[3]) is live.
- R9: coefDone is high for a channel's sample only when bypass was live for that channel through the whole previous frame and is still live. It drops as soon as bypass is left.
- R10: With PAIRED_MODE=1, writes to odd-numbered channels cannot set either mute bit. Their bypass and adaptation-off bits are still accepted.
- R11: After reset all outputs are 0 and every channel starts with all control bits clear (normal, adapting).
- R12: frameSync resets the channel index to 0. Each inValid cycle without frameSync produces, one clock later, outValid with outChan equal to that sample's index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSync | input | 1 | Frame start strobe; carries no sample |
| inValid | input | 1 | A sample for the next channel is present |
| rinData | input | DATA_W | Receive-side input sample |
| sinData | input | DATA_W | Send-side input sample |
| echoEst | input | DATA_W | Echo estimate supplied for the stub |
| ctrlWe | input | 1 | Stage a control write |
| ctrlChan | input | CH_W | Channel addressed by the write |
| ctrlBits | input | 4 | [0] send mute, [1] receive mute, [2] bypass, [3] adaptation off |
| outValid | output | 1 | Output sample present |
| outChan | output | CH_W | Channel of the output sample |
| routData | output | DATA_W | Receive-side output sample |
| soutData | output | DATA_W | Send-side output sample |
| coefClear | output | 1 | Request to zero the filter coefficients |
| adaptEn | output | 1 | Filter may update its coefficients |
| coefDone | output | 1 | Clear has been in force for a full frame |

## Verification
The bench builds the block with NUM_CH=4, QUIET_CODE=8'hD5 and PAIRED_MODE=1. With only four channels per frame, sixteen frames are enough to fill both delay lines, move a channel into bypass, hold it there and take it out again, and then re-enter bypass. This exposes the difference between the three-frame and two-frame send delays and the one-frame wait before coefDone. The non-default quiet code shows that muting uses the parameter rather than a fixed value. Paired mode lets the bench check that mute bits written to an odd channel are dropped.

// File: rtl/ecp_pkg.sv
package ecp_pkg;

  // Per-channel control word; bit order matches the ctrlBits port.
  typedef struct packed {
    logic adaptOff;
    logic bypass;
    logic muteRx;
    logic muteTx;
  } chanCtrl_t;

  // Per-sample strobes from the control unit to the datapath.
  typedef struct packed {
    logic valid;
    logic muteRx;
    logic muteTx;
    logic bypass;
    logic adaptEn;
    logic clearReq;
    logic clearDone;
  } pathStb_t;

endpackage

// File: rtl/ecp_ctrl_unit.sv
module ecp_ctrl_unit
  import ecp_pkg::*;
#(
  parameter int NUM_CH      = 32,
  parameter bit PAIRED_MODE = 1'b1,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            frameSync,
  input  logic            inValid,
  input  logic            ctrlWe,
  input  logic [CH_W-1:0] ctrlChan,
  input  logic [3:0]      ctrlBits,
  output pathStb_t        stb,
  output logic [CH_W-1:0] stbChan
);

  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  chanCtrl_t       staged  [NUM_CH];
  chanCtrl_t       live    [NUM_CH];
  logic            cleared [NUM_CH];
  logic [CH_W-1:0] chanCnt;
  chanCtrl_t       wrWord;
  chanCtrl_t       cur;

  // Mute bits of the second canceller of a pair are forced clear.
  generate
    if (PAIRED_MODE) begin : g_paired
      always_comb begin
        wrWord = chanCtrl_t'(ctrlBits);
        if (ctrlChan[0]) begin
          wrWord.muteTx = 1'b0;
          wrWord.muteRx = 1'b0;
        end
      end
    end else begin : g_single
      always_comb wrWord = chanCtrl_t'(ctrlBits);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanCnt <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        staged[c]  <= '0;
        live[c]    <= '0;
        cleared[c] <= 1'b0;
      end
    end else begin
      if (frameSync) begin
        chanCnt <= '0;
        for (int c = 0; c < NUM_CH; c++) begin
          live[c]    <= staged[c];
          // Cleared once a whole frame ran in bypass and bypass continues.
          cleared[c] <= live[c].bypass & staged[c].bypass;
        end
      end else if (inValid) begin
        chanCnt <= (chanCnt == LAST_CH) ? '0 : chanCnt + 1'b1;
      end
      if (ctrlWe && (int'(ctrlChan) < NUM_CH)) begin
        staged[ctrlChan] <= wrWord;
      end
    end
  end

  always_comb begin
    cur           = live[chanCnt];
    stb.valid     = inValid & ~frameSync;
    stb.muteRx    = cur.muteRx;
    stb.muteTx    = cur.muteTx;
    stb.bypass    = cur.bypass;
    stb.adaptEn   = ~cur.bypass & ~cur.adaptOff;
    stb.clearReq  = cur.bypass;
    stb.clearDone = cleared[chanCnt] & cur.bypass;
    stbChan       = chanCnt;
  end

endmodule

// File: rtl/ecp_data_path.sv
module ecp_data_path
  import ecp_pkg::*;
#(
  parameter int          NUM_CH     = 32,
  parameter int          DATA_W     = 8,
  parameter int          RX_DLY     = 2,
  parameter int          TX_DLY     = 3,
  parameter int          BYP_DLY    = 2,
  parameter logic [DATA_W-1:0] QUIET_CODE = 8'hFF,
  localparam int         CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathStb_t          stb,
  input  logic [CH_W-1:0]   stbChan,
  input  logic [DATA_W-1:0] rinData,
  input  logic [DATA_W-1:0] sinData,
  input  logic [DATA_W-1:0] echoEst,
  output logic              outValid,
  output logic [CH_W-1:0]   outChan,
  output logic [DATA_W-1:0] routData,
  output logic [DATA_W-1:0] soutData,
  output logic              coefClear,
  output logic              adaptEn,
  output logic              coefDone
);

  // Per-channel frame delay lines; tap 0 holds the newest sample.
  logic [DATA_W-1:0] rxTap  [RX_DLY][NUM_CH];
  logic [DATA_W-1:0] txTap  [TX_DLY][NUM_CH];
  logic [DATA_W-1:0] bypTap [BYP_DLY][NUM_CH];
  logic [DATA_W-1:0] cancelled;
  logic [DATA_W-1:0] rxOld;
  logic [DATA_W-1:0] txOld;
  logic [DATA_W-1:0] bypOld;

  // Stand-in for the filter: remove the supplied estimate.
  assign cancelled = sinData - echoEst;
  assign rxOld     = rxTap[RX_DLY-1][stbChan];
  assign txOld     = txTap[TX_DLY-1][stbChan];
  assign bypOld    = bypTap[BYP_DLY-1][stbChan];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int t = 0; t < RX_DLY; t++)
        for (int c = 0; c < NUM_CH; c++) rxTap[t][c] <= '0;
      for (int t = 0; t < TX_DLY; t++)
        for (int c = 0; c < NUM_CH; c++) txTap[t][c] <= '0;
      for (int t = 0; t < BYP_DLY; t++)
        for (int c = 0; c < NUM_CH; c++) bypTap[t][c] <= '0;
    end else if (stb.valid) begin
      for (int t = RX_DLY - 1; t > 0; t--) rxTap[t][stbChan] <= rxTap[t-1][stbChan];
      for (int t = TX_DLY - 1; t > 0; t--) txTap[t][stbChan] <= txTap[t-1][stbChan];
      for (int t = BYP_DLY - 1; t > 0; t--) bypTap[t][stbChan] <= bypTap[t-1][stbChan];
      rxTap[0][stbChan]  <= rinData;
      txTap[0][stbChan]  <= cancelled;
      bypTap[0][stbChan] <= sinData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outChan   <= '0;
      routData  <= '0;
      soutData  <= '0;
      coefClear <= 1'b0;
      adaptEn   <= 1'b0;
      coefDone  <= 1'b0;
    end else begin
      outValid  <= stb.valid;
      coefClear <= stb.valid & stb.clearReq;
      adaptEn   <= stb.valid & stb.adaptEn;
      coefDone  <= stb.valid & stb.clearDone;
      if (stb.valid) begin
        outChan  <= stbChan;
        routData <= stb.muteRx ? QUIET_CODE : rxOld;
        if (stb.muteTx)      soutData <= QUIET_CODE;
        else if (stb.bypass) soutData <= bypOld;
        else                 soutData <= txOld;
      end
    end
  end

endmodule

// File: rtl/echo_path_ctrl.sv
module echo_path_ctrl
  import ecp_pkg::*;
#(
  parameter int          NUM_CH      = 32,
  parameter int          DATA_W      = 8,
  parameter int          RX_DLY      = 2,
  parameter int          TX_DLY      = 3,
  parameter int          BYP_DLY     = 2,
  parameter logic [DATA_W-1:0] QUIET_CODE = 8'hFF,
  parameter bit          PAIRED_MODE = 1'b1,
  localparam int         CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameSync,
  input  logic              inValid,
  input  logic [DATA_W-1:0] rinData,
  input  logic [DATA_W-1:0] sinData,
  input  logic [DATA_W-1:0] echoEst,
  input  logic              ctrlWe,
  input  logic [CH_W-1:0]   ctrlChan,
  input  logic [3:0]        ctrlBits,
  output logic              outValid,
  output logic [CH_W-1:0]   outChan,
  output logic [DATA_W-1:0] routData,
  output logic [DATA_W-1:0] soutData,
  output logic              coefClear,
  output logic              adaptEn,
  output logic              coefDone
);

  pathStb_t        stbBus;
  logic [CH_W-1:0] stbChan;

  ecp_ctrl_unit #(
    .NUM_CH      (NUM_CH),
    .PAIRED_MODE (PAIRED_MODE)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameSync (frameSync),
    .inValid   (inValid),
    .ctrlWe    (ctrlWe),
    .ctrlChan  (ctrlChan),
    .ctrlBits  (ctrlBits),
    .stb       (stbBus),
    .stbChan   (stbChan)
  );

  ecp_data_path #(
    .NUM_CH     (NUM_CH),
    .DATA_W     (DATA_W),
    .RX_DLY     (RX_DLY),
    .TX_DLY     (TX_DLY),
    .BYP_DLY    (BYP_DLY),
    .QUIET_CODE (QUIET_CODE)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stbBus),
    .stbChan   (stbChan),
    .rinData   (rinData),
    .sinData   (sinData),
    .echoEst   (echoEst),
    .outValid  (outValid),
    .outChan   (outChan),
    .routData  (routData),
    .soutData  (soutData),
    .coefClear (coefClear),
    .adaptEn   (adaptEn),
    .coefDone  (coefDone)
  );

endmodule

// File: rtl/echo_path_chk.sv
module echo_path_chk
  import ecp_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter logic [DATA_W-1:0] QUIET_CODE = 8'hFF
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameSync,
  input logic              inValid,
  input pathStb_t          stb,
  input logic              outValid,
  input logic [DATA_W-1:0] routData,
  input logic [DATA_W-1:0] soutData,
  input logic              coefClear,
  input logic              adaptEn,
  input logic              coefDone
);

  a_r1_rx_mute_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (stb.valid && stb.muteRx) |=> (routData == QUIET_CODE));

  a_r2_tx_mute_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (stb.valid && stb.muteTx) |=> (soutData == QUIET_CODE));

  a_r3_mute_beats_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (stb.valid && stb.bypass && stb.muteTx && stb.muteRx) |=>
      (soutData == QUIET_CODE && routData == QUIET_CODE));

  a_r8_no_adapt_during_clear: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !(adaptEn && coefClear));

  a_r9_done_only_in_bypass: assert property (@(posedge clk) disable iff (!rstN)
    coefDone |-> coefClear);

  a_r12_sample_gives_output: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !frameSync) |=> outValid);

endmodule

bind echo_path_ctrl echo_path_chk #(
  .DATA_W     (DATA_W),
  .QUIET_CODE (QUIET_CODE)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .frameSync (frameSync),
  .inValid   (inValid),
  .stb       (stbBus),
  .outValid  (outValid),
  .routData  (routData),
  .soutData  (soutData),
  .coefClear (coefClear),
  .adaptEn   (adaptEn),
  .coefDone  (coefDone)
);

// File: tb/sim_echo_path_ctrl.sv
module sim_echo_path_ctrl;

  localparam int NCH  = 4;
  localparam int CHW  = 2;
  localparam logic [7:0] QC = 8'hD5;
  localparam int MAXF = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameSync = 1'b0, inValid = 1'b0, ctrlWe = 1'b0;
  logic [7:0] rinData = '0, sinData = '0, echoEst = '0;
  logic [CHW-1:0] ctrlChan = '0;
  logic [3:0] ctrlBits = '0;
  logic outValid, coefClear, adaptEn, coefDone;
  logic [CHW-1:0] outChan;
  logic [7:0] routData, soutData;

  always #4 clk = ~clk;

  echo_path_ctrl #(
    .NUM_CH(NCH), .DATA_W(8), .QUIET_CODE(QC), .PAIRED_MODE(1'b1)
  ) u0 (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .inValid(inValid),
    .rinData(rinData), .sinData(sinData), .echoEst(echoEst),
    .ctrlWe(ctrlWe), .ctrlChan(ctrlChan), .ctrlBits(ctrlBits),
    .outValid(outValid), .outChan(outChan), .routData(routData),
    .soutData(soutData), .coefClear(coefClear), .adaptEn(adaptEn),
    .coefDone(coefDone)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  string scen = "R11 defaults";

  // Reference model state
  int rinH [NCH][MAXF];
  int sinH [NCH][MAXF];
  int procH[NCH][MAXF];
  int kCnt [NCH];
  int byRun[NCH];
  logic [3:0] pend[NCH];
  logic [3:0] act [NCH];
  int chanM = 0;

  bit expValid = 0;
  int expChan, expR, expS, expA, expC, expD;
  string tagR, tagS;

  task automatic chk(string tag, int actv, int expv);
    total++;
    if (actv != expv) begin
      bad++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", tag, scen, actv, expv);
    end
  endtask

  task automatic compare();
    if (expValid) begin
      chk("R12 outValid", int'(outValid), 1);
      chk("R12 outChan", int'(outChan), expChan);
      chk(tagR, int'(routData), expR);
      chk(tagS, int'(soutData), expS);
      chk("R8 adaptEn", int'(adaptEn), expA);
      chk("R8 coefClear", int'(coefClear), expC);
      chk("R9 coefDone", int'(coefDone), expD);
    end else begin
      chk("R12 idle outValid", int'(outValid), 0);
    end
  endtask

  // One clock at a negedge: compare the last result, drive, predict.
  task automatic step(input bit fs, input bit v, input bit we,
                      input int wch, input logic [3:0] wb);
    compare();
    frameSync = fs;
    inValid   = v;
    ctrlWe    = we;
    ctrlChan  = CHW'(wch);
    ctrlBits  = wb;
    rinData   = 8'($urandom);
    sinData   = 8'($urandom);
    echoEst   = 8'($urandom);
    expValid  = 0;
    if (fs) begin
      for (int c = 0; c < NCH; c++) begin
        if (act[c][2] && pend[c][2]) byRun[c] = byRun[c] + 1;
        else byRun[c] = 0;
        act[c] = pend[c];
      end
      chanM = 0;
    end else if (v) begin
      int c, k;
      logic [3:0] b;
      c = chanM;
      k = kCnt[c];
      b = act[c];
      rinH[c][k]  = int'(rinData);
      sinH[c][k]  = int'(sinData);
      procH[c][k] = (int'(sinData) - int'(echoEst) + 256) % 256;
      expValid = 1;
      expChan  = c;
      if (b[1]) begin expR = QC; tagR = "R1 rout"; end
      else begin expR = (k >= 2) ? rinH[c][k-2] : 0; tagR = b[2] ? "R6 rout" : "R4 rout"; end
      if (b[0]) begin expS = QC; tagS = b[2] ? "R3 sout" : "R2 sout"; end
      else if (b[2]) begin expS = (k >= 2) ? sinH[c][k-2] : 0; tagS = "R6 sout"; end
      else begin expS = (k >= 3) ? procH[c][k-3] : 0; tagS = "R5 sout"; end
      expA = (!b[2] && !b[3]) ? 1 : 0;
      expC = b[2] ? 1 : 0;
      expD = (b[2] && byRun[c] >= 1) ? 1 : 0;
      kCnt[c] = k + 1;
      chanM = (chanM + 1) % NCH;
    end
    if (we && wch < NCH) begin
      logic [3:0] w;
      w = wb;
      if (wch % 2 == 1) w[1:0] = 2'b00;  // R10 paired odd channel
      pend[wch] = w;
    end
    @(negedge clk);
  endtask

  // A frame: strobe, then one sample per channel, an idle gap after
  // channel 1, and an optional write after sample wAt.
  task automatic runFrame(input int wAt, input int wch, input logic [3:0] wb);
    step(1, 0, 0, 0, 4'b0);
    for (int c = 0; c < NCH; c++) begin
      step(0, 1, 0, 0, 4'b0);
      if (c == 1) step(0, 0, 0, 0, 4'b0);
      if (c == wAt) step(0, 0, 1, wch, wb);
    end
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      kCnt[c] = 0; byRun[c] = 0; pend[c] = '0; act[c] = '0;
    end
    repeat (3) @(negedge clk);
    // R11: reset values
    chk("R11 reset outValid", int'(outValid), 0);
    chk("R11 reset routData", int'(routData), 0);
    chk("R11 reset soutData", int'(soutData), 0);
    chk("R11 reset adaptEn", int'(adaptEn), 0);
    chk("R11 reset coefDone", int'(coefDone), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 after release outValid", int'(outValid), 0);
    chk("R11 after release coefClear", int'(coefClear), 0);

    for (int f = 0; f < 4; f++) runFrame(-1, 0, 4'b0);
    scen = "R7 mid-frame write ch2 rx mute";
    runFrame(1, 2, 4'b0010);
    scen = "R7 bypass ch0";
    runFrame(0, 0, 4'b0100);
    scen = "R9 bypass held";
    runFrame(-1, 0, 4'b0);
    runFrame(2, 3, 4'b1000);
    scen = "R3 bypass with mutes";
    runFrame(0, 0, 4'b0111);
    scen = "R10 odd channel mutes dropped";
    runFrame(3, 1, 4'b1011);
    scen = "R2 tx mute ch2";
    runFrame(1, 2, 4'b0001);
    scen = "R9 leave bypass";
    runFrame(0, 0, 4'b0000);
    scen = "R9 re-enter bypass";
    runFrame(0, 0, 4'b0100);
    runFrame(-1, 0, 4'b0);
    runFrame(-1, 0, 4'b0);
    runFrame(-1, 0, 4'b0);
    compare();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog [%s] actual=timeout expected=finish", scen);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule